// File: doc/BRIEF.md
# Open-Row DRAM Command Sequencer

This block sits between a processor-side request port and a DRAM device command bus. It takes one read or write request at a time and splits the flat address into row, bank and column fields. It then drives the command sequence the device needs on a bus that carries either a row or a column address, depending on the command. Each bank keeps its own open row. When a request targets the row that is already open in its bank, the block skips straight to the column command. When the bank is closed, it opens the row first. When a different row is open, it closes that row, opens the requested one and then issues the column command.

Minimum gaps between dependent commands are counted in clock cycles and set by parameters: close-to-open (`T_RP`), open-to-column (`T_RCD`) and read-command-to-data (`T_CL`). Requests are served strictly in order. The requester sees `req_ready_o` low while a sequence is in flight. Read data comes back on a one-cycle response pulse.

Top module: `dram_row_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `req_ready_o` is 1, `cmd_o` is 0 (idle) and `rsp_valid_o` is 0. Reset closes every bank's row, so the first request to any bank after reset opens a row and does not close one.
- R2: The request address is split as {row, bank, column} from MSB to LSB. The column takes the `COL_W` low bits, the bank takes the next `log2(BANKS)` bits and the row takes the top `ROW_W` bits.
- R3: A request to a bank with no open row puts the open command (1) on `cmd_o` in the cycle after acceptance, with the row on `cmd_addr_o`. The column command follows exactly `T_RCD` cycles later.
- R4: A request whose row is already open in its bank puts the column command on `cmd_o` in the cycle after acceptance, with no open or close command.
- R5: A request to a bank with a different row open puts the close command (4) on `cmd_o` in the cycle after acceptance. The open command follows exactly `T_RP` cycles after the close, and the column command follows exactly `T_RCD` cycles after the open.
- R6: Command codes are: idle 0, open 1, read 2, write 3, close 4. No other value appears. `cmd_bank_o` carries the target bank with every command. `cmd_addr_o` carries the row with the open command and the zero-extended column with read and write. `cmd_wdata_o` carries the write data with the write command.
- R7: `rsp_valid_o` is high for exactly one cycle, `T_CL` cycles after the read command appears on `cmd_o`. In that cycle `rsp_rdata_o` equals `dram_rdata_i`.
- R8: `req_ready_o` is low from the cycle after acceptance until the sequence ends. For a write, the sequence ends in the cycle its write command is shown. For a read, it ends in the cycle of its response.
- R9: A request presented while `req_ready_o` is low is ignored. It produces no command and no memory change.
- R10: Each bank keeps its open row independently. Opening or closing a row in one bank does not change the hit, closed or conflict outcome for another bank.
- R11: `BANKS` may be 4 or 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ROW_W+log2(BANKS)+COL_W | Flat request address {row, bank, column} |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle read response pulse |
| rsp_rdata_o | output | DATA_W | Read data, valid with the pulse |
| cmd_o | output | 3 | Device command code |
| cmd_bank_o | output | log2(BANKS) | Target bank of the command |
| cmd_addr_o | output | max(ROW_W, COL_W) | Row or column address, shared pins |
| cmd_wdata_o | output | DATA_W | Write data, valid with the write command |
| dram_rdata_i | input | DATA_W | Read data from the device |

## Verification
The hardest situations to reach from the ports are two. The first is a request arriving while the block is busy. The second is a reset that lands in the middle of a close/open sequence, which must leave every bank closed. The stimulus table orders requests so that rows are first opened, then hit, then displaced in the same bank, while another bank keeps its own row. One conflicting read is run with a second, different write held on the request port for its whole duration. A later read of that write's address shows that the write never landed. A directed reset is applied just after a close command has gone out. Reads to banks that had open rows before the reset must then start with an open command.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dram_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_ACT_WAIT,
    ST_RD_WAIT
  } seq_state_e;
endpackage

// File: rtl/dram_addr_map.sv
module dram_addr_map #(
  parameter int ROW_W  = 4,
  parameter int BANK_W = 2,
  parameter int COL_W  = 3
) (
  input  logic [ROW_W+BANK_W+COL_W-1:0] addr_i,
  output logic [ROW_W-1:0]              row_o,
  output logic [BANK_W-1:0]             bank_o,
  output logic [COL_W-1:0]              col_o
);
  localparam int BANK_LO = COL_W;
  localparam int ROW_LO  = COL_W + BANK_W;

  assign col_o  = addr_i[COL_W-1:0];
  assign bank_o = addr_i[BANK_LO +: BANK_W];
  assign row_o  = addr_i[ROW_LO +: ROW_W];
endmodule

// File: rtl/dram_open_rows.sv
module dram_open_rows #(
  parameter int BANKS = 4,
  parameter int ROW_W = 4,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [BANK_W-1:0] upd_bank_i,
  input  logic [ROW_W-1:0]  upd_row_i,
  input  logic [BANK_W-1:0] lk_bank_i,
  output logic              lk_open_o,
  output logic [ROW_W-1:0]  lk_row_o
);
  logic [BANKS-1:0] open_vec;
  logic [ROW_W-1:0] row_vec [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : gen_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             sel;

    assign sel = (upd_bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (sel && set_i) begin
        open_q <= 1'b1;
        row_q  <= upd_row_i;
      end else if (sel && clr_i) begin
        open_q <= 1'b0;
      end
    end

    assign open_vec[b] = open_q;
    assign row_vec[b]  = row_q;
  end

  assign lk_open_o = open_vec[lk_bank_i];
  assign lk_row_o  = row_vec[lk_bank_i];
endmodule

// File: rtl/dram_gap_timer.sv
module dram_gap_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import dram_seq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 2,
  parameter int T_CL   = 3,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ADDR_W = ROW_W + BANK_W + COL_W,
  localparam int MUXA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [MUXA_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic [DATA_W-1:0] dram_rdata_i
);
  localparam int T_MAX0 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_MAX  = (T_MAX0 > T_CL) ? T_MAX0 : T_CL;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  seq_state_e state_q, state_d;

  logic [ROW_W-1:0]  in_row,  lat_row,  cur_row;
  logic [BANK_W-1:0] in_bank, lat_bank, cur_bank;
  logic [COL_W-1:0]  in_col,  lat_col,  cur_col;
  logic              lat_we,  cur_we;
  logic [DATA_W-1:0] lat_wdata, cur_wdata;

  logic              lk_open;
  logic [ROW_W-1:0]  lk_row;
  logic              tbl_set, tbl_clr;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              take;
  logic              do_pre, do_act, do_col;

  dram_cmd_e         cmd_q, cmd_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [MUXA_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              rsp_q, rsp_d;

  dram_addr_map #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) map_i (
    .addr_i (req_addr_i),
    .row_o  (in_row),
    .bank_o (in_bank),
    .col_o  (in_col)
  );

  dram_open_rows #(.BANKS(BANKS), .ROW_W(ROW_W)) rows_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (tbl_set),
    .clr_i      (tbl_clr),
    .upd_bank_i (cur_bank),
    .upd_row_i  (cur_row),
    .lk_bank_i  (in_bank),
    .lk_open_o  (lk_open),
    .lk_row_o   (lk_row)
  );

  dram_gap_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  // in idle the request port is the source, afterwards the latched copy
  always_comb begin
    if (state_q == ST_IDLE) begin
      cur_row = in_row; cur_bank = in_bank; cur_col = in_col;
      cur_we  = req_we_i; cur_wdata = req_wdata_i;
    end else begin
      cur_row = lat_row; cur_bank = lat_bank; cur_col = lat_col;
      cur_we  = lat_we; cur_wdata = lat_wdata;
    end
  end

  always_comb begin
    take   = 1'b0;
    do_pre = 1'b0;
    do_act = 1'b0;
    do_col = 1'b0;
    rsp_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          take = 1'b1;
          if (lk_open && (lk_row == in_row)) do_col = 1'b1;
          else if (lk_open)                  do_pre = 1'b1;
          else                               do_act = 1'b1;
        end
      end
      ST_PRE_WAIT: do_act = tmr_zero;
      ST_ACT_WAIT: do_col = tmr_zero;
      ST_RD_WAIT:  rsp_d  = tmr_zero;
      default: ;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    bank_d   = cur_bank;
    addr_d   = '0;
    wdata_d  = '0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tbl_set  = 1'b0;
    tbl_clr  = 1'b0;
    if (do_pre) begin
      cmd_d    = CMD_PRE;
      tbl_clr  = 1'b1;
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(T_RP - 1);
      state_d  = ST_PRE_WAIT;
    end
    if (do_act) begin
      cmd_d    = CMD_ACT;
      addr_d   = MUXA_W'(cur_row);
      tbl_set  = 1'b1;
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(T_RCD - 1);
      state_d  = ST_ACT_WAIT;
    end
    if (do_col) begin
      addr_d = MUXA_W'(cur_col);
      if (cur_we) begin
        cmd_d   = CMD_WR;
        wdata_d = cur_wdata;
        state_d = ST_IDLE;
      end else begin
        cmd_d    = CMD_RD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_CL - 1);
        state_d  = ST_RD_WAIT;
      end
    end
    if (rsp_d) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      bank_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      bank_q  <= bank_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rsp_q   <= rsp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_row   <= '0;
      lat_bank  <= '0;
      lat_col   <= '0;
      lat_we    <= 1'b0;
      lat_wdata <= '0;
    end else if (take) begin
      lat_row   <= in_row;
      lat_bank  <= in_bank;
      lat_col   <= in_col;
      lat_we    <= req_we_i;
      lat_wdata <= req_wdata_i;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rsp_q ? dram_rdata_i : '0;
  assign cmd_o       = cmd_q;
  assign cmd_bank_o  = bank_q;
  assign cmd_addr_o  = addr_q;
  assign cmd_wdata_o = wdata_q;
endmodule

// File: rtl/dram_row_seq_chk.sv
module dram_row_seq_chk #(
  parameter int BANKS = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 2,
  parameter int T_CL  = 3,
  localparam int BANK_W = $clog2(BANKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [2:0]        cmd_o,
  input logic [BANK_W-1:0] cmd_bank_o
);
  logic [15:0]       since_pre, since_act;
  logic              pre_seen, act_seen;
  logic [BANK_W-1:0] pre_bank, act_bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_pre <= '0; since_act <= '0;
      pre_seen  <= 1'b0; act_seen <= 1'b0;
      pre_bank  <= '0; act_bank <= '0;
    end else begin
      if (cmd_o == 3'd4) begin
        since_pre <= 16'd1; pre_seen <= 1'b1; pre_bank <= cmd_bank_o;
      end else if (since_pre != 16'hFFFF) begin
        since_pre <= since_pre + 16'd1;
      end
      if (cmd_o == 3'd1) begin
        since_act <= 16'd1; act_seen <= 1'b1; act_bank <= cmd_bank_o;
      end else if (since_act != 16'hFFFF) begin
        since_act <= since_act + 16'd1;
      end
    end
  end

  // R11
  initial bank_cfg_chk: assert (BANKS == 4 || BANKS == 8);

  // R6
  cmd_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o <= 3'd4);

  // R7
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R8
  rsp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  // R5
  pre_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd1 && pre_seen && cmd_bank_o == pre_bank) |-> since_pre >= 16'(T_RP));

  // R3
  act_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == 3'd2 || cmd_o == 3'd3) && act_seen && cmd_bank_o == act_bank)
      |-> since_act >= 16'(T_RCD));
endmodule

bind dram_row_seq dram_row_seq_chk #(
  .BANKS(BANKS), .T_RCD(T_RCD), .T_RP(T_RP), .T_CL(T_CL)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .cmd_o       (cmd_o),
  .cmd_bank_o  (cmd_bank_o)
);

// File: tb/dram_row_seq_tb_top.sv
`timescale 1ns/1ps
module dram_row_seq_tb_top;
  localparam int BANKS = 4, ROW_W = 4, COL_W = 3, DATA_W = 16;
  localparam int T_RCD = 3, T_RP = 2, T_CL = 3;
  localparam int BANK_W = 2, ADDR_W = 9, MUXA_W = 4;
  localparam int NVEC = 14;

  // {poke, kind(0 hit,1 closed,2 conflict), we, row, bank, col, data}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 2'd1, 1'b1, 4'd3,  2'd0, 3'd1, 16'hA1A1},
    {1'b0, 2'd0, 1'b1, 4'd3,  2'd0, 3'd2, 16'hA2A2},
    {1'b0, 2'd0, 1'b0, 4'd3,  2'd0, 3'd1, 16'h0000},
    {1'b0, 2'd2, 1'b0, 4'd5,  2'd0, 3'd1, 16'h0000},
    {1'b0, 2'd0, 1'b1, 4'd5,  2'd0, 3'd1, 16'hB1B1},
    {1'b0, 2'd2, 1'b0, 4'd3,  2'd0, 3'd2, 16'h0000},
    {1'b0, 2'd1, 1'b1, 4'd3,  2'd1, 3'd7, 16'hC7C7},
    {1'b0, 2'd0, 1'b0, 4'd3,  2'd0, 3'd2, 16'h0000},
    {1'b0, 2'd0, 1'b0, 4'd3,  2'd1, 3'd7, 16'h0000},
    {1'b0, 2'd1, 1'b1, 4'd15, 2'd3, 3'd0, 16'hD0D0},
    {1'b0, 2'd0, 1'b0, 4'd15, 2'd3, 3'd0, 16'h0000},
    {1'b1, 2'd2, 1'b0, 4'd0,  2'd3, 3'd0, 16'h0000},
    {1'b0, 2'd2, 1'b0, 4'd5,  2'd0, 3'd1, 16'h0000},
    {1'b0, 2'd1, 1'b1, 4'd0,  2'd2, 3'd7, 16'h7777}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready_o, rsp_valid_o;
  logic [DATA_W-1:0] rsp_rdata_o, cmd_wdata_o;
  logic [2:0] cmd_o;
  logic [BANK_W-1:0] cmd_bank_o;
  logic [MUXA_W-1:0] cmd_addr_o;
  logic [DATA_W-1:0] dram_rdata = '0;

  int checks = 0, errors = 0, cyc = 0;

  dram_row_seq #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                 .T_RCD(T_RCD), .T_RP(T_RP), .T_CL(T_CL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .cmd_o(cmd_o),
    .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o), .cmd_wdata_o(cmd_wdata_o),
    .dram_rdata_i(dram_rdata));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // device model and command monitor
  logic [DATA_W-1:0] mem  [512];
  logic [DATA_W-1:0] gold [512];
  logic [BANKS-1:0]  m_open = '0;
  logic [ROW_W-1:0]  m_row [BANKS];
  int n_pre = 0, n_act = 0, n_col = 0, n_rsp = 0;
  int t_pre = 0, t_act = 0, t_col = 0, t_rsp = 0;
  int act_addr = 0, col_addr = 0, col_bank = 0, col_cmd = 0, rsp_data = 0;

  always @(negedge clk) begin
    if (!rst_n) m_open <= '0;
    else begin
      case (cmd_o)
        3'd0: ;
        3'd4: begin
          chk(m_open[cmd_bank_o], "R6 close on open bank", 0, 1);
          m_open[cmd_bank_o] <= 1'b0; n_pre++; t_pre = cyc;
        end
        3'd1: begin
          chk(!m_open[cmd_bank_o], "R6 open on closed bank", 1, 0);
          m_open[cmd_bank_o] <= 1'b1; m_row[cmd_bank_o] <= cmd_addr_o;
          n_act++; t_act = cyc; act_addr = cmd_addr_o;
        end
        3'd2, 3'd3: begin
          chk(m_open[cmd_bank_o], "R6 column on open bank", 0, 1);
          n_col++; t_col = cyc; col_addr = cmd_addr_o; col_bank = cmd_bank_o; col_cmd = cmd_o;
          if (cmd_o == 3'd3) mem[{m_row[cmd_bank_o], cmd_bank_o, cmd_addr_o[COL_W-1:0]}] = cmd_wdata_o;
          else dram_rdata <= mem[{m_row[cmd_bank_o], cmd_bank_o, cmd_addr_o[COL_W-1:0]}];
        end
        default: chk(0, "R6 illegal command code", cmd_o, 0);
      endcase
      if (rsp_valid_o) begin n_rsp++; t_rsp = cyc; rsp_data = rsp_rdata_o; end
    end
  end

  task automatic do_req(input bit we, input int row, input int bank, input int col,
                        input int wdata, input int kind, input bit poke);
    int p0, a0, c0, r0, t_acc, busy_bad;
    logic [ADDR_W-1:0] a;
    bit done;
    a = {row[ROW_W-1:0], bank[BANK_W-1:0], col[COL_W-1:0]};
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    p0 = n_pre; a0 = n_act; c0 = n_col; r0 = n_rsp; busy_bad = 0;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wdata[DATA_W-1:0];
    if (we) gold[a] = wdata[DATA_W-1:0];
    @(negedge clk);
    if (poke) begin
      req_we = 1'b1; req_addr = {4'd5, 2'd0, 3'd1}; req_wdata = 16'hDEAD;
    end else req_valid = 1'b0;
    #1;
    t_acc = cyc - 0;
    for (int k = 0; k < 64; k++) begin
      done = we ? (n_col > c0) : (n_rsp > r0);
      if (done) break;
      if (req_ready_o) busy_bad++;
      @(negedge clk); #1;
    end
    req_valid = 1'b0;
    chk(busy_bad == 0, "R8 ready low during sequence", busy_bad, 0);
    chk(n_pre - p0 == (kind == 2 ? 1 : 0), "R5 close count", n_pre - p0, kind == 2);
    chk(n_act - a0 == (kind != 0 ? 1 : 0), "R3 open count", n_act - a0, kind != 0);
    chk(n_col - c0 == 1, "R9 single column command", n_col - c0, 1);
    if (kind == 0) chk(t_col == t_acc, "R4 hit column next cycle", t_col, t_acc);
    if (kind == 1) begin
      chk(t_act == t_acc, "R3 open next cycle", t_act, t_acc);
      chk(t_col == t_act + T_RCD, "R3 open-to-column gap", t_col - t_act, T_RCD);
    end
    if (kind == 2) begin
      chk(t_pre == t_acc, "R5 close next cycle", t_pre, t_acc);
      chk(t_act == t_pre + T_RP, "R5 close-to-open gap", t_act - t_pre, T_RP);
      chk(t_col == t_act + T_RCD, "R5 open-to-column gap", t_col - t_act, T_RCD);
    end
    if (kind != 0) chk(act_addr == row, "R6 row on address bus", act_addr, row);
    chk(col_addr == col && col_bank == bank, "R2 column and bank fields", {col_bank, col_addr}, {bank, col});
    chk(col_cmd == (we ? 3 : 2), "R6 column command code", col_cmd, we ? 3 : 2);
    if (!we) begin
      chk(t_rsp == t_col + T_CL, "R7 read latency", t_rsp - t_col, T_CL);
      chk(rsp_data == gold[a], "R10 read data", rsp_data, gold[a]);
      @(negedge clk); #1;
      chk(!rsp_valid_o, "R7 one-cycle pulse", rsp_valid_o, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin mem[i] = '0; gold[i] = '0; end
    for (int b = 0; b < BANKS; b++) m_row[b] = '0;
    #1;
    chk(req_ready_o && cmd_o == 0 && !rsp_valid_o, "R1 outputs in reset",
        {req_ready_o, cmd_o, rsp_valid_o}, 5'b10000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready_o && cmd_o == 0 && !rsp_valid_o, "R1 state after reset",
        {req_ready_o, cmd_o, rsp_valid_o}, 5'b10000);

    for (int v = 0; v < NVEC; v++)
      do_req(VEC[v][25], int'(VEC[v][24:21]), int'(VEC[v][20:19]), int'(VEC[v][18:16]),
             int'(VEC[v][15:0]), int'(VEC[v][27:26]), VEC[v][28]);

    // reset in the middle of a conflict sequence on bank 2
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = {4'd9, 2'd2, 3'd0};
    @(negedge clk); req_valid = 1'b0;
    #1;
    chk(cmd_o == 3'd4, "R5 close issued before reset", cmd_o, 4);
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk(req_ready_o && cmd_o == 0 && !rsp_valid_o, "R1 outputs during mid-sequence reset",
        {req_ready_o, cmd_o, rsp_valid_o}, 5'b10000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (T_CL + T_RCD + 2) begin
      @(negedge clk); #1;
      chk(cmd_o == 0 && !rsp_valid_o, "R1 idle after reset", cmd_o, 0);
    end
    // banks 0 and 1 had open rows before reset; now they must be closed
    do_req(1'b0, 3, 1, 7, 0, 1, 1'b0);
    do_req(1'b0, 3, 0, 2, 0, 1, 1'b0);
    do_req(1'b0, 15, 3, 0, 0, 1, 1'b0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule